// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer (byte/word)

This block sits between a synchronous requester and an external parallel ROM that has no clock of its own. The ROM can present either 16-bit words or 8-bit bytes, chosen by a mode-select line. A request carries a word address, a width flag and, for byte reads, a byte-select bit. The sequencer drives the ROM's active-low chip and output enables, the address and the mode line. It waits the ROM's access times, converted to whole clock cycles, then latches the data bus. It returns a 16-bit result, zero-extended for bytes, together with a one-cycle valid strobe.

In byte mode the top data line of the ROM becomes an address input that selects the upper or lower half of the word. The sequencer drives that line with the byte select and never takes it as data. In word mode the line is a normal output and the sequencer leaves it alone.

Reads of the same width can be chained: the next request is taken on the edge that captures the current one, and the enables stay asserted. A read that ends the chain, or a change of width, releases both enables. The sequencer then holds off new work until the ROM outputs have had time to float.

Top module: `rom_rd_ctrl`

## Requirements
- R1: During and after reset, with no request pending: rom_ce_n=1, rom_oe_n=1, rom_word=1, rom_lsb_oe=0, rsp_valid=0, req_ready=1.
- R2: A word read (req_byte=0) drives rom_word=1 and rom_lsb_oe=0, and returns all 16 bus bits, rsp_data=rom_dq[15:0].
- R3: A byte read (req_byte=1) drives rom_word=0, rom_lsb_oe=1 and rom_lsb_out=req_hi, and returns rsp_data={8'h00, rom_dq[7:0]}; rom_dq[15:8] does not reach the result.
- R4: When a read starts from idle, the capture edge falls F clock edges after the accept edge, where F is the largest of ceil(TAA_NS/CLK_NS), ceil(TACE_NS/CLK_NS) and ceil(TOE_NS/CLK_NS). rsp_valid is high during the cycle that follows the capture edge.
- R5: A request of the same width that is valid during a capture cycle is accepted on that capture edge. rom_ce_n and rom_oe_n stay 0, and its own capture comes ceil(TAA_NS/CLK_NS) edges later.
- R6: rom_addr, rom_word and rom_lsb_out hold their values from the accept edge until the capture edge of that read.
- R7: When no request is taken at a capture edge, rom_ce_n and rom_oe_n go to 1 on that edge. req_ready then stays 0 for exactly ceil(TDF_NS/CLK_NS) cycles, and the next accept comes no earlier than the edge after that.
- R8: A request whose width differs from the running read is not accepted at the capture edge. The enables are released, the float gap of R7 passes, and the request then starts as a fresh read timed by R4.
- R9: rom_oe_n is 0 only while rom_ce_n is 0, and rom_lsb_oe is never 1 while the ROM may still be driving line 15 in word mode, including the float time after a release.
- R10: Each accepted request produces exactly one rsp_valid pulse, and responses come back in the order of the requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request is taken on this edge when req_valid is high |
| req_addr | input | AW | Word address |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| req_hi | input | 1 | Byte read: 1 selects the upper byte of the word |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 16 | Read result, zero-extended for bytes |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM mode line: 1 word, 0 byte |
| rom_addr | output | AW | ROM word address |
| rom_lsb_out | output | 1 | Value driven onto data line 15 in byte mode |
| rom_lsb_oe | output | 1 | Drive enable for data line 15 |
| rom_dq | input | 16 | ROM data bus as seen by the controller |

## Verification
The bench builds the block with AW=8, CLK_NS=10, TAA_NS=115, TACE_NS=125, TOE_NS=72 and TDF_NS=25. None of these times is a whole number of cycles, so every conversion has to round up. The chip-enable time, at 13 cycles, sets the wait from idle, while the address time sets the 12-cycle chained wait. A wrong choice between the two is therefore visible at the ports. The float time of 3 cycles is long enough to expose an early byte-mode drive of line 15 after a word read. The behavioural ROM presents garbage until each deadline has passed, so a capture one cycle early shows up as a miscompare.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // byte results keep only the low lane; upper lines are not data then
  function automatic logic [15:0] shape_rsp(input logic byte_mode, input logic [15:0] dq);
    return byte_mode ? {8'h00, dq[7:0]} : dq;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // done is high in the last cycle of the window: the edge ending it is the deadline
  assign done = (cnt == CW'(1));

  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/rom_rd_capture.sv
module rom_rd_capture import rom_rd_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic        byte_mode,
  input  logic [15:0] dq,
  output logic        rsp_valid,
  output logic [15:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cap;
      if (cap) rsp_data <= shape_rsp(byte_mode, dq);
    end
  end

  p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && byte_mode) |=> (rsp_data[15:8] == 8'h00));

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl import rom_rd_pkg::*; #(
  parameter int AW      = 22,
  parameter int CLK_NS  = 10,
  parameter int TAA_NS  = 120,
  parameter int TACE_NS = 120,
  parameter int TOE_NS  = 60,
  parameter int TDF_NS  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_byte,
  input  logic          req_hi,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  output logic          rom_word,
  output logic [AW-1:0] rom_addr,
  output logic          rom_lsb_out,
  output logic          rom_lsb_oe,
  input  logic [15:0]   rom_dq
);

  localparam int AA_CYC    = ns_to_cyc(TAA_NS, CLK_NS);
  localparam int CE_CYC    = ns_to_cyc(TACE_NS, CLK_NS);
  localparam int OE_CYC    = ns_to_cyc(TOE_NS, CLK_NS);
  localparam int DF_CYC    = ns_to_cyc(TDF_NS, CLK_NS);
  localparam int FIRST_CYC = max3(AA_CYC, CE_CYC, OE_CYC);
  localparam int MAX_CYC   = max3(FIRST_CYC, DF_CYC, 1);
  localparam int CW        = $clog2(MAX_CYC + 1);
  localparam int GW        = $clog2(DF_CYC + 2);

  rd_state_e     st;
  logic          mode_byte;
  logic [AW-1:0] addr_q;
  logic          lsb_q;
  logic          ce_n_q;
  logic          oe_n_q;

  // named events, shared by the FSM and the assertions
  logic          cap_evt;
  logic          float_end;
  logic          accept;
  logic          chain;
  logic          release_evt;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic [GW-1:0] rel_cnt;

  always_comb begin
    cap_evt     = (st == ST_ACCESS) && tmr_done;
    float_end   = (st == ST_FLOAT) && tmr_done;
    req_ready   = (st == ST_IDLE) || (cap_evt && (req_byte == mode_byte));
    accept      = req_valid && req_ready;
    chain       = accept && cap_evt;
    release_evt = cap_evt && !accept;
    tmr_load    = accept || release_evt;
    if (release_evt) tmr_val = CW'(DF_CYC);
    else if (chain)  tmr_val = CW'(AA_CYC);
    else             tmr_val = CW'(FIRST_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mode_byte <= 1'b0;
      addr_q    <= '0;
      lsb_q     <= 1'b0;
      ce_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
    end else if (accept) begin
      st        <= ST_ACCESS;
      mode_byte <= req_byte;
      addr_q    <= req_addr;
      lsb_q     <= req_hi;
      ce_n_q    <= 1'b0;
      oe_n_q    <= 1'b0;
    end else if (release_evt) begin
      st        <= ST_FLOAT;
      ce_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
    end else if (float_end) begin
      st        <= ST_IDLE;
    end
  end

  // cycles the chip enable has been released, saturating; checker state only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rel_cnt <= GW'(DF_CYC + 1);
    else if (!rom_ce_n)              rel_cnt <= '0;
    else if (rel_cnt < GW'(DF_CYC + 1)) rel_cnt <= rel_cnt + 1'b1;
  end

  rom_rd_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  rom_rd_capture i_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap_evt),
    .byte_mode (mode_byte),
    .dq        (rom_dq),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign rom_ce_n    = ce_n_q;
  assign rom_oe_n    = oe_n_q;
  assign rom_addr    = addr_q;
  assign rom_word    = !mode_byte;
  assign rom_lsb_oe  = mode_byte;
  assign rom_lsb_out = lsb_q & mode_byte;

  p_oe_needs_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n);

  p_hold_during_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ACCESS) && !cap_evt) |=> ($stable(rom_addr) && $stable(rom_word) && $stable(rom_lsb_out)));

  p_accept_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!rom_ce_n && !rom_oe_n));

  p_width_change_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && req_valid && (req_byte != mode_byte)) |=> (rom_ce_n && rom_oe_n && !req_ready));

  p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (rel_cnt >= GW'(DF_CYC)));

  p_capture_gives_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> rsp_valid);

endmodule

// File: tb/test_rom_rd_ctrl.sv
`timescale 1ns/1ps
module test_rom_rd_ctrl;

  localparam int AW = 8;
  localparam int CLK = 10;
  localparam int TAA = 115;
  localparam int TACE = 125;
  localparam int TOE = 72;
  localparam int TDF = 25;

  function automatic int to_cyc(input int ns);
    return ns / CLK + ((ns % CLK) != 0 ? 1 : 0);
  endfunction

  localparam int AAC = to_cyc(TAA);
  localparam int FIRSTC = (to_cyc(TACE) > AAC) ? ((to_cyc(TACE) > to_cyc(TOE)) ? to_cyc(TACE) : to_cyc(TOE))
                                               : ((AAC > to_cyc(TOE)) ? AAC : to_cyc(TOE));
  localparam int DFC = to_cyc(TDF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic req_byte = 1'b0;
  logic req_hi = 1'b0;
  logic rsp_valid;
  logic [15:0] rsp_data;
  logic rom_ce_n, rom_oe_n, rom_word, rom_lsb_out, rom_lsb_oe;
  logic [AW-1:0] rom_addr;
  logic [15:0] rom_dq = 16'h55AA;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_clash = 0;
  int n_oe_bad = 0;

  always #(CLK/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  rom_rd_ctrl #(.AW(AW), .CLK_NS(CLK), .TAA_NS(TAA), .TACE_NS(TACE), .TOE_NS(TOE), .TDF_NS(TDF)) i_rom_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .req_hi(req_hi),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word(rom_word), .rom_addr(rom_addr),
    .rom_lsb_out(rom_lsb_out), .rom_lsb_oe(rom_lsb_oe), .rom_dq(rom_dq)
  );

  // ---------------- behavioural ROM ----------------
  function automatic logic [15:0] rom_fn(input logic [AW-1:0] a);
    return {a ^ 8'hC3, a ^ 8'h5A};
  endfunction

  realtime t_addr = -1000.0, t_ce = -1000.0, t_oe = -1000.0, t_rel = -1000.0;
  logic was_word = 1'b1;

  always @(rom_addr or rom_lsb_out or rom_word) t_addr = $realtime;
  always @(negedge rom_ce_n) t_ce = $realtime;
  always @(negedge rom_oe_n) t_oe = $realtime;
  always @(posedge rom_ce_n or posedge rom_oe_n) begin
    t_rel = $realtime;
    was_word = rom_word;
  end

  // bus is evaluated at falling edges: valid there iff the next rising edge is past every deadline
  always @(negedge clk) begin
    realtime now;
    logic en, ok, drv15;
    logic [15:0] w, bus;
    now = $realtime;
    en = !rom_ce_n && !rom_oe_n;
    ok = (now - t_addr >= TAA - CLK/2) && (now - t_ce >= TACE - CLK/2) && (now - t_oe >= TOE - CLK/2);
    w = rom_fn(rom_addr);
    if (!en) bus = 16'h55AA;
    else if (!ok) bus = 16'hBAD5;
    else if (rom_word) bus = w;
    else bus = {1'b1, 7'h2A, rom_lsb_out ? w[15:8] : w[7:0]};
    if (!rom_word) bus[15] = rom_lsb_oe ? rom_lsb_out : 1'b1;
    drv15 = (en && rom_word) || (was_word && ((now - t_rel) < TDF));
    if (rom_lsb_oe && drv15) n_clash = n_clash + 1;
    if (!rom_oe_n && rom_ce_n) n_oe_bad = n_oe_bad + 1;
    rom_dq = bus;
  end

  // ---------------- check helper ----------------
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- sequence runner ----------------
  logic [AW-1:0] sq_addr [8];
  logic sq_byte [8];
  logic sq_hi [8];
  int acc_c [8];
  int rsp_c [8];
  logic [15:0] rsp_d [8];
  logic [AW-1:0] pin_addr [8];
  logic pin_word [8];
  logic pin_lsb [8];

  task automatic run_seq(input int n);
    int prev_cap;
    fork
      begin
        for (int k = 0; k < n; k++) begin
          int g;
          req_valid = 1'b1;
          req_addr = sq_addr[k];
          req_byte = sq_byte[k];
          req_hi = sq_hi[k];
          #1;
          g = 0;
          while (!req_ready && g < 400) begin
            @(negedge clk); #1; g++;
          end
          acc_c[k] = cyc + 1;
          @(negedge clk);
        end
        req_valid = 1'b0;
      end
      begin
        logic [AW-1:0] pa;
        logic pw, pl;
        pa = rom_addr; pw = rom_word; pl = rom_lsb_out;
        for (int k = 0; k < n; k++) begin
          int g;
          g = 0;
          rsp_c[k] = -1;
          while (g < 400) begin
            @(negedge clk);
            g++;
            if (rsp_valid) begin
              rsp_c[k] = cyc; rsp_d[k] = rsp_data;
              pin_addr[k] = pa; pin_word[k] = pw; pin_lsb[k] = pl;
              break;
            end
            pa = rom_addr; pw = rom_word; pl = rom_lsb_out;
          end
        end
      end
    join
    prev_cap = -100;
    for (int k = 0; k < n; k++) begin
      int expc;
      logic [15:0] w, expd;
      bit b2b;
      b2b = (acc_c[k] == prev_cap);
      expc = acc_c[k] + (b2b ? AAC : FIRSTC);
      w = rom_fn(sq_addr[k]);
      expd = sq_byte[k] ? {8'h00, sq_hi[k] ? w[15:8] : w[7:0]} : w;
      if (b2b) chk(rsp_c[k] == expc, "R5", "chained capture cycle", rsp_c[k], expc);
      else     chk(rsp_c[k] == expc, "R4", "first capture cycle", rsp_c[k], expc);
      chk(rsp_d[k] == expd, sq_byte[k] ? "R3" : "R2", "read data", rsp_d[k], expd);
      chk(pin_addr[k] == sq_addr[k] && pin_word[k] == !sq_byte[k] && (!sq_byte[k] || pin_lsb[k] == sq_hi[k]),
          "R6", "pins held until capture", {pin_addr[k], 3'b0, pin_word[k], 3'b0, pin_lsb[k]},
          {sq_addr[k], 3'b0, !sq_byte[k], 3'b0, sq_hi[k]});
      prev_cap = expc;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(rom_ce_n == 1'b1 && rom_oe_n == 1'b1, "R1", "enables idle", {rom_ce_n, rom_oe_n}, 2'b11);
    chk(rom_word == 1'b1 && rom_lsb_oe == 1'b0, "R1", "mode/line15 idle", {rom_word, rom_lsb_oe}, 2'b10);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", "rsp/ready idle", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic t_word_single;
    int n;
    sq_addr[0] = 8'h3C; sq_byte[0] = 1'b0; sq_hi[0] = 1'b0;
    run_seq(1);
    chk(rom_ce_n && rom_oe_n, "R7", "enables released after last read", {rom_ce_n, rom_oe_n}, 2'b11);
    n = 0;
    while (!req_ready && n < 50) begin
      @(negedge clk); #1; n++;
    end
    chk(n == DFC, "R7", "ready-low cycles in float gap", n, DFC);
    chk(rsp_valid == 1'b0, "R10", "single pulse per read", rsp_valid, 0);
  endtask

  task automatic t_byte_pair;
    sq_addr[0] = 8'h81; sq_byte[0] = 1'b1; sq_hi[0] = 1'b1;
    sq_addr[1] = 8'h81; sq_byte[1] = 1'b1; sq_hi[1] = 1'b0;
    sq_addr[2] = 8'hF0; sq_byte[2] = 1'b1; sq_hi[2] = 1'b1;
    run_seq(3);
    repeat (DFC + 2) @(negedge clk);
  endtask

  task automatic t_word_burst;
    for (int k = 0; k < 5; k++) begin
      sq_addr[k] = 8'(8'h10 + 8'(k * 37)); sq_byte[k] = 1'b0; sq_hi[k] = 1'b0;
    end
    run_seq(5);
    chk(rsp_c[4] - rsp_c[0] == 4 * AAC, "R10", "five ordered responses span", rsp_c[4] - rsp_c[0], 4 * AAC);
    repeat (DFC + 2) @(negedge clk);
  endtask

  task automatic t_width_switch;
    sq_addr[0] = 8'h22; sq_byte[0] = 1'b0; sq_hi[0] = 1'b0;
    sq_addr[1] = 8'h22; sq_byte[1] = 1'b1; sq_hi[1] = 1'b1;
    sq_addr[2] = 8'h23; sq_byte[2] = 1'b0; sq_hi[2] = 1'b0;
    run_seq(3);
    chk(acc_c[1] == rsp_c[0] + DFC + 1, "R8", "word->byte accept after float", acc_c[1], rsp_c[0] + DFC + 1);
    chk(acc_c[2] == rsp_c[1] + DFC + 1, "R8", "byte->word accept after float", acc_c[2], rsp_c[1] + DFC + 1);
    repeat (DFC + 2) @(negedge clk);
  endtask

  task automatic t_bus_rules;
    chk(n_clash == 0, "R9", "line 15 driven while ROM drives it", n_clash, 0);
    chk(n_oe_bad == 0, "R9", "output enable without chip enable", n_oe_bad, 0);
  endtask

  // ---------------- main and watchdog ----------------
  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_word_single;
    t_byte_pair;
    t_word_burst;
    t_width_switch;
    t_bus_rules;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk = n_chk + 1;
    n_bad = n_bad + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule